// File: doc/BRIEF.md
# Set-Associative Cache Lookup and Line Store

This block holds a set-associative cache's tags, valid bits, line data and replacement state. It looks up the tag store and the data store side by side. Each address names one whole line, so there is no word select. Four control inputs (request, read/write, invalidate, replace) choose one command per clock. The block can read, update with a per-byte write mask, read-then-drop and write-then-drop a resident line, and it reports hit or miss for each of these. It has no backing-memory interface. The surrounding refill logic swaps a line in two steps. First a victim read returns the line that would be evicted and its full address. Then a victim write installs the new tag and the whole new line.

The set index is the low `$clog2(N_LINES/N_WAYS)` address bits and the tag is the rest. Each set keeps an exact least-recently-used order as one age per way, where 0 is newest and `N_WAYS-1` is oldest. A small state machine remembers the way chosen by a victim read. It has two states. `ST_IDLE` means no victim is held. `ST_HELD` means a victim way and set have been latched. The transitions are:
- IDLE→HELD on a victim read.
- HELD→HELD on another victim read (which re-latches) or on a no-op.
- HELD→IDLE on a victim write or on any request command.

A victim write uses the held way when it targets the held set. If it does not, it picks a fresh victim.

Top module: `setassoc_cache`

## Requirements
- R1: Commands are decoded from {request_i, rw_i, inval_i, replace_i}: 1000 read, 1100 update, 1010 read-and-drop, 1110 write-and-drop, 0001 victim read, 0101 victim write. Every other combination is a no-op. A no-op changes no stored state, drives hit_o and miss_o low, and leaves line_o and old_addr_o unchanged.
- R2: For the four request commands, hit_o is 1 when a valid way of the addressed set holds the tag, and miss_o is 1 otherwise. Both are 0 for every other command. With HIT_REG=1 they appear one cycle after the command; with HIT_REG=0 they appear in the same cycle.
- R3: After a synchronous reset every way is invalid, all tags and data are zero, and hit_o, miss_o, line_o and old_addr_o are 0. Every lookup misses until a line is installed.
- R4: A read or read-and-drop that hits places the line on line_o one cycle later. A miss leaves line_o unchanged.
- R5: An update or write-and-drop that hits writes byte b (bits 8b+7..8b) from line_i only when keep_mask_i[b] is 0. When keep_mask_i[b] is 1 the stored byte is kept.
- R6: A request that misses changes no tag, valid bit or data.
- R7: Read-and-drop and write-and-drop that hit report a hit and then clear the way's valid bit, so the next lookup of that address misses.
- R8: The victim is the lowest-numbered invalid way of the set if one exists, and otherwise the least-recently-used way. Hits and victim writes make the way newest; drops make it oldest.
- R9: A victim read drives line_o with the victim's content and old_addr_o with {victim tag, set index}, with the set index in the low bits, one cycle later.
- R10: A victim write stores all bytes of line_i whatever keep_mask_i holds, installs the tag as valid, and shows line_i on line_o one cycle later.
- R11: old_addr_o changes only after a victim read.
- R12: Sets are independent: commands on one set never change hits or contents in another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous active-high reset |
| request_i | input | 1 | Lookup command select |
| rw_i | input | 1 | 1 = write, 0 = read |
| inval_i | input | 1 | Drop the line after a hit |
| replace_i | input | 1 | Victim read/write step select |
| addr_i | input | ADDR_W | Line address (set index in low bits) |
| keep_mask_i | input | LINE_W/8 | Per-byte mask, 1 keeps the stored byte |
| line_i | input | LINE_W | Line write data |
| line_o | output | LINE_W | Line read data |
| hit_o | output | 1 | Lookup found the tag |
| miss_o | output | 1 | Lookup did not find the tag |
| old_addr_o | output | ADDR_W | Address of the victim line |

## Verification
The hardest case to reach is an LRU victim choice in a full set, because every way must be filled and the age order must then be steered. The bench fills all four ways of one set through victim reads and writes. It then touches the oldest way with a read, so the expected victim moves to a way it can name ahead of time. It also drops one way so the invalid-first rule overrides age. A second instance with combinational hit/miss gets the same stimulus and is sampled before the clock edge.

// File: rtl/setassoc_pkg.sv
package setassoc_pkg;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_READ,
        CMD_UPDATE,
        CMD_READ_DROP,
        CMD_WRITE_DROP,
        CMD_VICTIM_READ,
        CMD_VICTIM_WRITE
    } cmd_e;

    typedef enum logic {
        ST_IDLE,
        ST_HELD
    } state_e;

    function automatic cmd_e decode_cmd(input logic req, input logic rw,
                                        input logic inv, input logic rep);
        cmd_e c;
        case ({req, rw, inv, rep})
            4'b1000: c = CMD_READ;
            4'b1100: c = CMD_UPDATE;
            4'b1010: c = CMD_READ_DROP;
            4'b1110: c = CMD_WRITE_DROP;
            4'b0001: c = CMD_VICTIM_READ;
            4'b0101: c = CMD_VICTIM_WRITE;
            default: c = CMD_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/setassoc_store.sv
module setassoc_store #(
    parameter int N_SETS = 1,
    parameter int N_WAYS = 32,
    parameter int SET_W  = 1,
    parameter int WAY_W  = 5,
    parameter int TAG_W  = 8,
    parameter int LINE_W = 8
) (
    input  logic                               clk_i,
    input  logic                               rst_i,
    input  logic [SET_W-1:0]                   set_i,
    output logic [N_WAYS-1:0]                  valid_o,
    output logic [N_WAYS-1:0][TAG_W-1:0]       tag_o,
    output logic [N_WAYS-1:0][LINE_W-1:0]      data_o,
    input  logic [WAY_W-1:0]                   wr_way_i,
    input  logic                               wr_en_i,
    input  logic [LINE_W/8-1:0]                byte_en_i,
    input  logic [LINE_W-1:0]                  wr_line_i,
    input  logic                               tag_we_i,
    input  logic [TAG_W-1:0]                   wr_tag_i,
    input  logic                               set_valid_i,
    input  logic                               clr_valid_i
);
    localparam int N_BYTES = LINE_W / 8;

    logic              valid_q [N_SETS][N_WAYS];
    logic [TAG_W-1:0]  tag_q   [N_SETS][N_WAYS];
    logic [LINE_W-1:0] data_q  [N_SETS][N_WAYS];

    always_comb begin
        for (int w = 0; w < N_WAYS; w++) begin
            valid_o[w] = valid_q[set_i][w];
            tag_o[w]   = tag_q[set_i][w];
            data_o[w]  = data_q[set_i][w];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int s = 0; s < N_SETS; s++) begin
                for (int w = 0; w < N_WAYS; w++) begin
                    valid_q[s][w] <= 1'b0;
                    tag_q[s][w]   <= '0;
                    data_q[s][w]  <= '0;
                end
            end
        end else begin
            if (tag_we_i) begin
                tag_q[set_i][wr_way_i] <= wr_tag_i;
            end
            if (set_valid_i) begin
                valid_q[set_i][wr_way_i] <= 1'b1;
            end else if (clr_valid_i) begin
                valid_q[set_i][wr_way_i] <= 1'b0;
            end
            if (wr_en_i) begin
                for (int b = 0; b < N_BYTES; b++) begin
                    if (byte_en_i[b]) begin
                        data_q[set_i][wr_way_i][b*8 +: 8] <= wr_line_i[b*8 +: 8];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/setassoc_lru.sv
module setassoc_lru #(
    parameter int N_SETS = 1,
    parameter int N_WAYS = 32,
    parameter int SET_W  = 1,
    parameter int WAY_W  = 5
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [SET_W-1:0]  set_i,
    input  logic [N_WAYS-1:0] valid_i,
    output logic [WAY_W-1:0]  victim_o,
    input  logic              touch_i,
    input  logic              drop_i,
    input  logic [WAY_W-1:0]  way_i
);
    localparam logic [WAY_W-1:0] OLDEST = WAY_W'(N_WAYS - 1);

    logic [WAY_W-1:0] age_q [N_SETS][N_WAYS];
    logic [WAY_W-1:0] sel_age;
    logic             found;

    assign sel_age = age_q[set_i][way_i];

    always_comb begin
        victim_o = '0;
        found    = 1'b0;
        for (int w = 0; w < N_WAYS; w++) begin
            if (!found && !valid_i[w]) begin
                victim_o = WAY_W'(w);
                found    = 1'b1;
            end
        end
        if (!found) begin
            for (int w = 0; w < N_WAYS; w++) begin
                if (age_q[set_i][w] == OLDEST) begin
                    victim_o = WAY_W'(w);
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int s = 0; s < N_SETS; s++) begin
                for (int w = 0; w < N_WAYS; w++) begin
                    age_q[s][w] <= WAY_W'(w);
                end
            end
        end else if (touch_i || drop_i) begin
            for (int w = 0; w < N_WAYS; w++) begin
                if (WAY_W'(w) == way_i) begin
                    age_q[set_i][w] <= touch_i ? '0 : OLDEST;
                end else if (touch_i && age_q[set_i][w] < sel_age) begin
                    age_q[set_i][w] <= age_q[set_i][w] + 1'b1;
                end else if (drop_i && age_q[set_i][w] > sel_age) begin
                    age_q[set_i][w] <= age_q[set_i][w] - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/setassoc_cache.sv
module setassoc_cache
    import setassoc_pkg::*;
#(
    parameter int N_LINES = 32,
    parameter int N_WAYS  = 32,
    parameter int ADDR_W  = 8,
    parameter int LINE_W  = 8,
    parameter bit HIT_REG = 1'b1
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                request_i,
    input  logic                rw_i,
    input  logic                inval_i,
    input  logic                replace_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [LINE_W/8-1:0] keep_mask_i,
    input  logic [LINE_W-1:0]   line_i,
    output logic [LINE_W-1:0]   line_o,
    output logic                hit_o,
    output logic                miss_o,
    output logic [ADDR_W-1:0]   old_addr_o
);
    localparam int N_SETS   = N_LINES / N_WAYS;
    localparam int SET_BITS = $clog2(N_SETS);
    localparam int SET_W    = (SET_BITS > 0) ? SET_BITS : 1;
    localparam int TAG_W    = ADDR_W - SET_BITS;
    localparam int WAY_W    = (N_WAYS > 1) ? $clog2(N_WAYS) : 1;
    localparam int N_BYTES  = LINE_W / 8;

    cmd_e   cmd;
    state_e state_q, state_d;

    logic [SET_W-1:0]                 set_idx;
    logic [TAG_W-1:0]                 tag_in;
    logic [N_WAYS-1:0]                way_valid;
    logic [N_WAYS-1:0][TAG_W-1:0]     way_tag;
    logic [N_WAYS-1:0][LINE_W-1:0]    way_data;
    logic                             hit_any;
    logic [WAY_W-1:0]                 hit_way, victim_way, fill_way;
    logic [WAY_W-1:0]                 held_way_q;
    logic [SET_W-1:0]                 held_set_q;
    logic [ADDR_W-1:0]                victim_addr;
    logic                             lookup;

    logic                wr_en, tag_we, set_valid, clr_valid, touch, drop;
    logic [WAY_W-1:0]    wr_way;
    logic [N_BYTES-1:0]  byte_en;

    logic [LINE_W-1:0]   line_q;
    logic [ADDR_W-1:0]   old_q;
    logic                hit_q, miss_q;

    assign cmd    = decode_cmd(request_i, rw_i, inval_i, replace_i);
    assign tag_in = addr_i[ADDR_W-1:SET_BITS];
    assign lookup = (cmd == CMD_READ) || (cmd == CMD_UPDATE) ||
                    (cmd == CMD_READ_DROP) || (cmd == CMD_WRITE_DROP);

    generate
        if (SET_BITS > 0) begin : g_sets
            assign set_idx     = addr_i[SET_W-1:0];
            assign victim_addr = {way_tag[victim_way], set_idx};
        end else begin : g_one_set
            assign set_idx     = '0;
            assign victim_addr = way_tag[victim_way];
        end
    endgenerate

    setassoc_store #(
        .N_SETS(N_SETS), .N_WAYS(N_WAYS), .SET_W(SET_W),
        .WAY_W(WAY_W), .TAG_W(TAG_W), .LINE_W(LINE_W)
    ) store_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .set_i      (set_idx),
        .valid_o    (way_valid),
        .tag_o      (way_tag),
        .data_o     (way_data),
        .wr_way_i   (wr_way),
        .wr_en_i    (wr_en),
        .byte_en_i  (byte_en),
        .wr_line_i  (line_i),
        .tag_we_i   (tag_we),
        .wr_tag_i   (tag_in),
        .set_valid_i(set_valid),
        .clr_valid_i(clr_valid)
    );

    setassoc_lru #(
        .N_SETS(N_SETS), .N_WAYS(N_WAYS), .SET_W(SET_W), .WAY_W(WAY_W)
    ) lru_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .set_i   (set_idx),
        .valid_i (way_valid),
        .victim_o(victim_way),
        .touch_i (touch),
        .drop_i  (drop),
        .way_i   (wr_way)
    );

    // Tag compare across all ways of the addressed set.
    always_comb begin
        hit_any = 1'b0;
        hit_way = '0;
        for (int w = N_WAYS - 1; w >= 0; w--) begin
            if (way_valid[w] && way_tag[w] == tag_in) begin
                hit_any = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
    end

    assign fill_way = hit_any ? hit_way :
                      (state_q == ST_HELD && held_set_q == set_idx) ? held_way_q :
                      victim_way;

    // Next state of the victim-hold machine.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd == CMD_VICTIM_READ) state_d = ST_HELD;
            ST_HELD: if (cmd != CMD_NONE && cmd != CMD_VICTIM_READ) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Array and LRU update strobes per command.
    always_comb begin
        wr_en     = 1'b0;
        tag_we    = 1'b0;
        set_valid = 1'b0;
        clr_valid = 1'b0;
        touch     = 1'b0;
        drop      = 1'b0;
        byte_en   = '0;
        wr_way    = hit_way;
        unique case (cmd)
            CMD_READ: touch = hit_any;
            CMD_UPDATE: begin
                wr_en   = hit_any;
                byte_en = ~keep_mask_i;
                touch   = hit_any;
            end
            CMD_READ_DROP: begin
                clr_valid = hit_any;
                drop      = hit_any;
            end
            CMD_WRITE_DROP: begin
                wr_en     = hit_any;
                byte_en   = ~keep_mask_i;
                clr_valid = hit_any;
                drop      = hit_any;
            end
            CMD_VICTIM_WRITE: begin
                wr_en     = 1'b1;
                byte_en   = '1;
                tag_we    = 1'b1;
                set_valid = 1'b1;
                touch     = 1'b1;
                wr_way    = fill_way;
            end
            default: ;
        endcase
    end

    // State register.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q    <= ST_IDLE;
            held_way_q <= '0;
            held_set_q <= '0;
        end else begin
            state_q <= state_d;
            if (cmd == CMD_VICTIM_READ) begin
                held_way_q <= victim_way;
                held_set_q <= set_idx;
            end
        end
    end

    // Output registers.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            line_q <= '0;
            old_q  <= '0;
            hit_q  <= 1'b0;
            miss_q <= 1'b0;
        end else begin
            hit_q  <= lookup & hit_any;
            miss_q <= lookup & ~hit_any;
            unique case (cmd)
                CMD_READ, CMD_READ_DROP: if (hit_any) line_q <= way_data[hit_way];
                CMD_VICTIM_READ: begin
                    line_q <= way_data[victim_way];
                    old_q  <= victim_addr;
                end
                CMD_VICTIM_WRITE: line_q <= line_i;
                default: ;
            endcase
        end
    end

    generate
        if (HIT_REG) begin : g_hit_reg
            assign hit_o  = hit_q;
            assign miss_o = miss_q;
        end else begin : g_hit_comb
            assign hit_o  = lookup & hit_any;
            assign miss_o = lookup & ~hit_any;
        end
    endgenerate

    assign line_o     = line_q;
    assign old_addr_o = old_q;

endmodule

// File: rtl/setassoc_cache_chk.sv
module setassoc_cache_chk #(
    parameter int ADDR_W  = 8,
    parameter int LINE_W  = 8,
    parameter bit HIT_REG = 1'b1
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              request_i,
    input logic              rw_i,
    input logic              replace_i,
    input logic              hit_o,
    input logic              miss_o,
    input logic [LINE_W-1:0] line_o,
    input logic [ADDR_W-1:0] old_addr_o
);
    // R2: hit and miss never together
    p_hit_miss_excl_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !(hit_o && miss_o));

    // R2: registered mode reports only after a request command
    p_quiet_without_req_r2: assert property (@(posedge clk_i) disable iff (rst_i || !HIT_REG)
        !request_i |=> (!hit_o && !miss_o));

    // R1: a cycle with neither request nor replace keeps line_o
    p_noop_line_hold_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (!request_i && !replace_i) |=> $stable(line_o));

    // R11: old_addr_o moves only after a victim read
    p_old_addr_hold_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        !(replace_i && !request_i && !rw_i) |=> $stable(old_addr_o));

endmodule

bind setassoc_cache setassoc_cache_chk #(
    .ADDR_W(ADDR_W), .LINE_W(LINE_W), .HIT_REG(HIT_REG)
) chk_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .request_i (request_i),
    .rw_i      (rw_i),
    .replace_i (replace_i),
    .hit_o     (hit_o),
    .miss_o    (miss_o),
    .line_o    (line_o),
    .old_addr_o(old_addr_o)
);

// File: tb/setassoc_cache_tb_top.sv
module setassoc_cache_tb_top;
    localparam int N_LINES = 8;
    localparam int N_WAYS  = 4;
    localparam int ADDR_W  = 6;
    localparam int LINE_W  = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req = 1'b0, rw = 1'b0, inv = 1'b0, rep = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [1:0]        kmask = '0;
    logic [LINE_W-1:0] din = '0;
    logic [LINE_W-1:0] line_r, line_c;
    logic              hit_r, miss_r, hit_c, miss_c;
    logic [ADDR_W-1:0] old_r, old_c;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    setassoc_cache #(.N_LINES(N_LINES), .N_WAYS(N_WAYS), .ADDR_W(ADDR_W),
                     .LINE_W(LINE_W), .HIT_REG(1'b1)) dut_i (
        .clk_i(clk), .rst_i(rst), .request_i(req), .rw_i(rw), .inval_i(inv),
        .replace_i(rep), .addr_i(addr), .keep_mask_i(kmask), .line_i(din),
        .line_o(line_r), .hit_o(hit_r), .miss_o(miss_r), .old_addr_o(old_r));

    setassoc_cache #(.N_LINES(N_LINES), .N_WAYS(N_WAYS), .ADDR_W(ADDR_W),
                     .LINE_W(LINE_W), .HIT_REG(1'b0)) dut_comb_i (
        .clk_i(clk), .rst_i(rst), .request_i(req), .rw_i(rw), .inval_i(inv),
        .replace_i(rep), .addr_i(addr), .keep_mask_i(kmask), .line_i(din),
        .line_o(line_c), .hit_o(hit_c), .miss_o(miss_c), .old_addr_o(old_c));

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // One command for one cycle; outputs are sampled at the following negedge.
    task automatic cmd(input logic q, input logic w, input logic i, input logic r,
                       input logic [ADDR_W-1:0] a, input logic [LINE_W-1:0] d,
                       input logic [1:0] m);
        @(negedge clk);
        req = q; rw = w; inv = i; rep = r; addr = a; din = d; kmask = m;
        @(negedge clk);
        req = 1'b0; rw = 1'b0; inv = 1'b0; rep = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a);
        cmd(1, 0, 0, 0, a, '0, 2'b00);
    endtask

    task automatic t_reset();
        check("R3 hit after reset", {31'b0, hit_r}, 0);
        check("R3 miss after reset", {31'b0, miss_r}, 0);
        check("R3 line after reset", {16'b0, line_r}, 0);
        check("R3 old addr after reset", {26'b0, old_r}, 0);
        rd(6'h02);
        check("R3 cold lookup misses", {30'b0, hit_r, miss_r}, 32'd1);
    endtask

    task automatic t_fill();
        for (int k = 0; k < 4; k++) begin
            cmd(0, 0, 0, 1, 6'(2 * (k + 1)), '0, 2'b00);
            if (k == 0) begin
                check("R9 empty victim old addr", {26'b0, old_r}, 0);
                check("R2 no hit on victim read", {30'b0, hit_r, miss_r}, 0);
            end
            cmd(0, 1, 0, 1, 6'(2 * (k + 1)), 16'(16'h1111 * (k + 1)), 2'b00);
            check("R10 victim write line out", {16'b0, line_r}, 32'(16'h1111 * (k + 1)));
        end
    endtask

    task automatic t_lru();
        rd(6'h02);
        check("R4 read hit data", {16'b0, line_r}, 32'h1111);
        cmd(0, 0, 0, 1, 6'h0A, '0, 2'b00);
        check("R8 LRU victim address", {26'b0, old_r}, 32'h04);
        check("R9 victim line data", {16'b0, line_r}, 32'h2222);
        cmd(0, 1, 0, 1, 6'h0A, 16'h5555, 2'b00);
        rd(6'h04);
        check("R8 evicted line misses", {30'b0, hit_r, miss_r}, 32'd1);
        rd(6'h0A);
        check("R10 installed line hits", {30'b0, hit_r, miss_r}, 32'd2);
        check("R10 installed line data", {16'b0, line_r}, 32'h5555);
    endtask

    task automatic t_mask();
        cmd(1, 1, 0, 0, 6'h02, 16'hBEEF, 2'b10);
        check("R2 update hit", {30'b0, hit_r, miss_r}, 32'd2);
        rd(6'h02);
        check("R5 masked byte kept", {16'b0, line_r}, 32'h11EF);
    endtask

    task automatic t_miss_write();
        cmd(1, 1, 0, 0, 6'h0C, 16'hFFFF, 2'b00);
        check("R2 update miss", {30'b0, hit_r, miss_r}, 32'd1);
        rd(6'h0C);
        check("R6 missed write installs nothing", {30'b0, hit_r, miss_r}, 32'd1);
        check("R4 miss holds line", {16'b0, line_r}, 32'h11EF);
        rd(6'h06);
        check("R6 other line intact", {16'b0, line_r}, 32'h3333);
    endtask

    task automatic t_drop();
        cmd(1, 0, 1, 0, 6'h06, '0, 2'b00);
        check("R7 read-drop hit", {30'b0, hit_r, miss_r}, 32'd2);
        check("R7 read-drop data", {16'b0, line_r}, 32'h3333);
        rd(6'h06);
        check("R7 dropped line misses", {30'b0, hit_r, miss_r}, 32'd1);
        cmd(0, 0, 0, 1, 6'h0E, '0, 2'b00);
        check("R8 invalid way preferred", {26'b0, old_r}, 32'h06);
        cmd(0, 1, 0, 1, 6'h0E, 16'h6666, 2'b00);
        rd(6'h0E);
        check("R10 refill into dropped way", {16'b0, line_r}, 32'h6666);
        cmd(1, 1, 1, 0, 6'h08, 16'h7777, 2'b00);
        check("R7 write-drop hit", {30'b0, hit_r, miss_r}, 32'd2);
        rd(6'h08);
        check("R7 write-drop then miss", {30'b0, hit_r, miss_r}, 32'd1);
    endtask

    task automatic t_set();
        rd(6'h03);
        check("R12 other set still empty", {30'b0, hit_r, miss_r}, 32'd1);
        cmd(0, 0, 0, 1, 6'h03, '0, 2'b00);
        check("R9 set index in low bits", {26'b0, old_r}, 32'h01);
        cmd(0, 1, 0, 1, 6'h03, 16'h9A9A, 2'b11);
        rd(6'h03);
        check("R10 full write ignores mask", {16'b0, line_r}, 32'h9A9A);
        rd(6'h0A);
        check("R12 set0 line unaffected", {16'b0, line_r}, 32'h5555);
    endtask

    task automatic t_noop();
        cmd(0, 1, 0, 0, 6'h03, 16'h0000, 2'b00);
        check("R1 no-op hit/miss low", {30'b0, hit_r, miss_r}, 0);
        check("R1 no-op line held", {16'b0, line_r}, 32'h5555);
        cmd(1, 1, 0, 1, 6'h03, 16'h0000, 2'b00);
        check("R1 illegal combo quiet", {30'b0, hit_r, miss_r}, 0);
        check("R11 old addr held", {26'b0, old_r}, 32'h01);
        rd(6'h03);
        check("R1 illegal combo wrote nothing", {16'b0, line_r}, 32'h9A9A);
    endtask

    task automatic t_comb();
        @(negedge clk);
        req = 1'b1; addr = 6'h03;
        #1;
        check("R2 combinational hit same cycle", {30'b0, hit_c, miss_c}, 32'd2);
        addr = 6'h04;
        #1;
        check("R2 combinational miss same cycle", {30'b0, hit_c, miss_c}, 32'd1);
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fill();
        t_lru();
        t_mask();
        t_miss_write();
        t_drop();
        t_set();
        t_noop();
        t_comb();
        finish_run();
    end

endmodule